// File: doc/BRIEF.md
# Floating-Point Subnormal Input Conditioner

This block sits ahead of a floating-point datapath and prepares each source operand before any arithmetic sees it. It holds a 32-bit control/status register for the vector floating-point unit, classifies every presented operand as subnormal or not (single or double precision, chosen per operand), and, when the flush control bit is on, replaces a subnormal operand with a zero of the same sign. When flushing is off, subnormal operands pass through untouched. A sticky status flag then records the event, and an exception request is raised unless the matching mask bit hides it.

Register writes are screened against a writable-bit mask that the block exposes on a port, so software can learn which bits are legal. A write that tries to set any bit outside that mask is refused: the register keeps its old contents and a one-cycle protection fault pulse follows. A build parameter decides whether the flush control exists at all. Without it, the flush bit always reads zero and setting it faults.

Register bits used: bit 1 is the sticky subnormal-input flag, bit 6 is the flush enable, bit 8 is the subnormal-input exception mask. All other bits are reserved.

Top module: `fpcond_top`

## Requirements
- R1: After synchronous active-low reset the register reads 0x0000_0100 (mask bit 8 set, flush bit 6 and flag bit 1 clear) and the fault output is low.
- R2: With op_dp=0 the operand is op_in[31:0] with exponent [30:23] and fraction [22:0]. It is reported subnormal exactly when the exponent is all zeros and the fraction is nonzero; a zero exponent with a zero fraction is a zero and is not subnormal; op_in[63:32] does not affect the result.
- R3: With op_dp=1 the operand is op_in[63:0] with exponent [62:52] and fraction [51:0], classified by the same rule.
- R4: With bit 6 set, a subnormal operand is output as zero with its original sign (bit 31 for single, bit 63 for double); in single precision op_out[63:32] equals op_in[63:32]. Non-subnormal operands always pass unchanged.
- R5: With bit 6 set, a valid subnormal operand neither sets flag bit 1 nor raises the exception request, whatever mask bit 8 holds.
- R6: With bit 6 clear, a valid subnormal operand passes unmodified, sets flag bit 1 at the next clock edge, and raises the exception request in the same cycle only when mask bit 8 is clear.
- R7: Flag bit 1 is sticky: it stays set until a legal register write carrying a zero in bit 1.
- R8: csr_wmask reads 0x0000_0142 when flushing is supported. A write with any bit set outside that mask leaves the register unchanged and makes csr_fault high for exactly the one cycle after the write edge. Legal writes never fault.
- R9: When flushing is not supported, csr_wmask reads 0x0000_0102, bit 6 always reads zero, writing zero to it is legal, and writing one to it faults.
- R10: An operand in the same cycle as a register write is conditioned by the register value from before the write, and a flag set by that operand is ORed into the newly written value.
- R11: With op_valid low, the flag is not set and no exception request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 32 | Register write value |
| csr_rd_data | output | 32 | Current register contents |
| csr_wmask | output | 32 | Bits that may legally be written as one |
| csr_fault | output | 1 | Protection fault, one cycle after an illegal write |
| op_valid | input | 1 | Operand present this cycle |
| op_dp | input | 1 | 1 = double precision, 0 = single precision |
| op_in | input | 64 | Source operand |
| op_out | output | 64 | Conditioned operand |
| op_is_dnrm | output | 1 | Operand classified as subnormal |
| dnrm_exc_req | output | 1 | Subnormal-input exception request |

## Verification
A register write and a subnormal operand can arrive in the same cycle, and both then try to update the register. The bench writes the flush enable while presenting an unflushed subnormal with the flag clear. It then judges that the operand was handled under the old setting (unmodified output, exception request raised) and that the register afterwards holds both the new flush bit and the flag the operand set. The same collision with an illegal write is covered by the fault-stability assertion, which ignores the flag bit.

// File: rtl/fpcond_pkg.sv
// Shared widths and encodings for the operand conditioner.
package fpcond_pkg;
    localparam int OP_W      = 64;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int N_FMT     = 2;

    typedef enum logic {
        PREC_SINGLE = 1'b0,
        PREC_DOUBLE = 1'b1
    } prec_e;
endpackage

// File: rtl/fpcond_classify.sv
// Classifies one IEEE-style word as subnormal.
// Assumes the word is {sign, exponent, fraction} with the sign at the top.
module fpcond_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  is_dnrm
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              sign_unused;

    // Split the word into its fields and apply the zero-exponent rule.
    always_comb begin
        {sign_unused, exp_f, frac_f} = word;
        is_dnrm = (exp_f == '0) && (frac_f != '0);
    end
endmodule

// File: rtl/fpcond_flush.sv
// Replaces a subnormal operand by a signed zero when flushing is on.
// Assumes single precision lives in the low 32 bits; upper bits are kept.
module fpcond_flush
    import fpcond_pkg::*;
(
    input  logic [OP_W-1:0] op_in,
    input  prec_e           prec,
    input  logic            is_dnrm,
    input  logic            flush_en,
    output logic [OP_W-1:0] op_out
);
    // Select the pass-through or zeroed value for the chosen format.
    always_comb begin
        op_out = op_in;
        if (flush_en && is_dnrm) begin
            if (prec == PREC_DOUBLE)
                op_out = {op_in[OP_W-1], {(OP_W-1){1'b0}}};
            else
                op_out = {op_in[OP_W-1:SP_W], op_in[SP_W-1], {(SP_W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/fpcond_csr.sv
// Control/status register with write screening and a sticky flag.
// Assumes an operand-driven flag set takes effect alongside any write.
module fpcond_csr #(
    parameter int CSR_W     = 32,
    parameter int FLAG_BIT  = 1,
    parameter int FLUSH_BIT = 6,
    parameter int MASK_BIT  = 8,
    parameter bit SUPPORTED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             flag_set,
    output logic [CSR_W-1:0] rd_data,
    output logic [CSR_W-1:0] wmask,
    output logic             fault
);
    localparam logic [CSR_W-1:0] ONE     = {{(CSR_W-1){1'b0}}, 1'b1};
    localparam logic [CSR_W-1:0] FLUSH_M = SUPPORTED ? (ONE << FLUSH_BIT) : '0;
    localparam logic [CSR_W-1:0] WMASK   = (ONE << FLAG_BIT) | (ONE << MASK_BIT) | FLUSH_M;
    localparam logic [CSR_W-1:0] RST_VAL = ONE << MASK_BIT;

    logic [CSR_W-1:0] csr_q;
    logic             fault_q;
    logic             illegal;
    logic [CSR_W-1:0] set_v;

    // Decode write legality and the flag-set vector.
    always_comb begin
        illegal = (wr_data & ~WMASK) != '0;
        set_v   = flag_set ? (ONE << FLAG_BIT) : '0;
    end

    // Register update: legal writes replace, flag sets always OR in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q   <= RST_VAL;
            fault_q <= 1'b0;
        end else begin
            if (wr_en && !illegal)
                csr_q <= (wr_data & WMASK) | set_v;
            else
                csr_q <= csr_q | set_v;
            fault_q <= wr_en && illegal;
        end
    end

    assign rd_data = csr_q;
    assign wmask   = WMASK;
    assign fault   = fault_q;
endmodule

// File: rtl/fpcond_top.sv
// Subnormal operand conditioner: classify, optionally flush, report.
// Assumes one operand per cycle, conditioned by the current register value.
module fpcond_top
    import fpcond_pkg::*;
#(
    parameter int CSR_W           = 32,
    parameter int FLAG_BIT        = 1,
    parameter int FLUSH_BIT       = 6,
    parameter int MASK_BIT        = 8,
    parameter bit FLUSH_SUPPORTED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wr_data,
    output logic [CSR_W-1:0] csr_rd_data,
    output logic [CSR_W-1:0] csr_wmask,
    output logic             csr_fault,
    input  logic             op_valid,
    input  logic             op_dp,
    input  logic [OP_W-1:0]  op_in,
    output logic [OP_W-1:0]  op_out,
    output logic             op_is_dnrm,
    output logic             dnrm_exc_req
);
    logic [N_FMT-1:0] dn_v;
    prec_e            prec;
    logic             flush_en;
    logic             flag_set;

    // One classifier per supported format.
    for (genvar f = 0; f < N_FMT; f++) begin : g_cls
        localparam int EW = (f == 1) ? DP_EXP_W  : SP_EXP_W;
        localparam int FW = (f == 1) ? DP_FRAC_W : SP_FRAC_W;
        fpcond_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls (
            .word    (op_in[EW+FW:0]),
            .is_dnrm (dn_v[f])
        );
    end

    // Pick the classification and derive flag and exception requests.
    always_comb begin
        prec         = prec_e'(op_dp);
        op_is_dnrm   = (prec == PREC_DOUBLE) ? dn_v[1] : dn_v[0];
        flush_en     = csr_rd_data[FLUSH_BIT];
        flag_set     = op_valid && op_is_dnrm && !flush_en;
        dnrm_exc_req = flag_set && !csr_rd_data[MASK_BIT];
    end

    fpcond_flush u_flush (
        .op_in    (op_in),
        .prec     (prec),
        .is_dnrm  (op_is_dnrm),
        .flush_en (flush_en),
        .op_out   (op_out)
    );

    fpcond_csr #(
        .CSR_W     (CSR_W),
        .FLAG_BIT  (FLAG_BIT),
        .FLUSH_BIT (FLUSH_BIT),
        .MASK_BIT  (MASK_BIT),
        .SUPPORTED (FLUSH_SUPPORTED)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr_en),
        .wr_data  (csr_wr_data),
        .flag_set (flag_set),
        .rd_data  (csr_rd_data),
        .wmask    (csr_wmask),
        .fault    (csr_fault)
    );
endmodule

// File: rtl/fpcond_chk.sv
// Property checker for fpcond_top, attached by bind.
// Assumes it observes only the top-level ports.
module fpcond_chk #(
    parameter int CSR_W     = 32,
    parameter int FLAG_BIT  = 1,
    parameter int FLUSH_BIT = 6,
    parameter int MASK_BIT  = 8,
    parameter bit SUPPORTED = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr_en,
    input logic [CSR_W-1:0] csr_rd_data,
    input logic             csr_fault,
    input logic             op_valid,
    input logic             op_is_dnrm,
    input logic             dnrm_exc_req
);
    localparam logic [CSR_W-1:0] ONE  = {{(CSR_W-1){1'b0}}, 1'b1};
    localparam logic [CSR_W-1:0] KEEP = ~(ONE << FLAG_BIT);
    logic sup_q;
    assign sup_q = SUPPORTED;

    // R5
    flush_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd_data[FLUSH_BIT] |-> !dnrm_exc_req);

    // R5
    flush_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && csr_rd_data[FLUSH_BIT] && !csr_wr_en && !csr_rd_data[FLAG_BIT])
        |=> !csr_rd_data[FLAG_BIT]);

    // R6
    flag_on_dnrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_dnrm && !csr_rd_data[FLUSH_BIT]) |=> csr_rd_data[FLAG_BIT]);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd_data[FLAG_BIT] && !csr_wr_en) |=> csr_rd_data[FLAG_BIT]);

    // R8
    fault_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_fault |-> ((csr_rd_data & KEEP) == ($past(csr_rd_data) & KEEP)));

    // R9
    no_flush_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_q |-> !csr_rd_data[FLUSH_BIT]);

    // R11
    idle_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !dnrm_exc_req);
endmodule

bind fpcond_top fpcond_chk #(
    .CSR_W     (CSR_W),
    .FLAG_BIT  (FLAG_BIT),
    .FLUSH_BIT (FLUSH_BIT),
    .MASK_BIT  (MASK_BIT),
    .SUPPORTED (FLUSH_SUPPORTED)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_wr_en    (csr_wr_en),
    .csr_rd_data  (csr_rd_data),
    .csr_fault    (csr_fault),
    .op_valid     (op_valid),
    .op_is_dnrm   (op_is_dnrm),
    .dnrm_exc_req (dnrm_exc_req)
);

// File: tb/fpcond_top_tb.sv
// Self-checking bench: vector table, then directed reset and corner tests.
module fpcond_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, nd_wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0, op_dp = 1'b0;
    logic [63:0] op_in = '0;
    logic [31:0] rd, wmask, nd_rd, nd_wmask;
    logic        fault, nd_fault, dn, exc, nd_dn, nd_exc;
    logic [63:0] op_out, nd_out;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    fpcond_top u_dut (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wr_data(wr_data),
        .csr_rd_data(rd), .csr_wmask(wmask), .csr_fault(fault),
        .op_valid(op_valid), .op_dp(op_dp), .op_in(op_in),
        .op_out(op_out), .op_is_dnrm(dn), .dnrm_exc_req(exc));

    fpcond_top #(.FLUSH_SUPPORTED(1'b0)) u_dut_nd (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(nd_wr_en), .csr_wr_data(wr_data),
        .csr_rd_data(nd_rd), .csr_wmask(nd_wmask), .csr_fault(nd_fault),
        .op_valid(op_valid), .op_dp(op_dp), .op_in(op_in),
        .op_out(nd_out), .op_is_dnrm(nd_dn), .dnrm_exc_req(nd_exc));

    typedef struct packed {
        logic        dp;
        logic [31:0] csr;
        logic [63:0] opnd;
        logic [63:0] res;
        logic        dn;
        logic        exc;
        logic        flag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h100, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b1},
        '{1'b0, 32'h000, 64'h0000_0000_8040_0000, 64'h0000_0000_8040_0000, 1'b1, 1'b1, 1'b1},
        '{1'b0, 32'h000, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h000, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h140, 64'hDEAD_BEEF_807F_FFFF, 64'hDEAD_BEEF_8000_0000, 1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h040, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h000, 64'h000F_FFFF_FFFF_FFFF, 64'h000F_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1},
        '{1'b1, 32'h040, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h040, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 32'h000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 32'h000, 64'h4000_0000_0000_0001, 64'h4000_0000_0000_0001, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h000, 64'h0000_0001_3F80_0000, 64'h0000_0001_3F80_0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_csr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr_nd(input logic [31:0] d);
        @(negedge clk); nd_wr_en = 1'b1; wr_data = d;
        @(negedge clk); nd_wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd", 64'(rd), 64'h100);
        chk("R1 fault", 64'(fault), 64'h0);
        chk("R9 reset rd", 64'(nd_rd), 64'h100);
        rst_n = 1'b1;
        chk("R8 wmask", 64'(wmask), 64'h142);
        chk("R9 wmask", 64'(nd_wmask), 64'h102);

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr_csr(VECS[i].csr);
            @(negedge clk);
            op_valid = 1'b1; op_dp = VECS[i].dp; op_in = VECS[i].opnd;
            #1;
            chk($sformatf("R2/R3/R4 out v%0d", i), op_out, VECS[i].res);
            chk($sformatf("R2/R3 dnrm v%0d", i), 64'(dn), 64'(VECS[i].dn));
            chk($sformatf("R5/R6 exc v%0d", i), 64'(exc), 64'(VECS[i].exc));
            @(negedge clk); op_valid = 1'b0;
            chk($sformatf("R5/R6 flag v%0d", i), 64'(rd[1]), 64'(VECS[i].flag));
        end

        // R11 idle operand has no effect
        wr_csr(32'h000);
        @(negedge clk); op_valid = 1'b0; op_dp = 1'b0; op_in = 64'h1;
        #1 chk("R11 exc", 64'(exc), 64'h0);
        @(negedge clk);
        chk("R11 flag", 64'(rd), 64'h000);

        // R10 write and subnormal operand in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h040; op_valid = 1'b1; op_dp = 1'b0; op_in = 64'h1;
        #1;
        chk("R10 exc old csr", 64'(exc), 64'h1);
        chk("R10 out old csr", op_out, 64'h1);
        @(negedge clk); wr_en = 1'b0; op_valid = 1'b0;
        chk("R10 rd merged", 64'(rd), 64'h042);

        // R7 sticky until written
        @(negedge clk); op_valid = 1'b1; op_in = 64'h0000_0000_3F80_0000;
        @(negedge clk); op_valid = 1'b0;
        chk("R7 flag held", 64'(rd), 64'h042);
        wr_csr(32'h040);
        chk("R7 flag cleared", 64'(rd), 64'h040);

        // R8 illegal writes
        wr_csr(32'h100);
        wr_csr(32'h141);
        chk("R8 fault bit0", 64'(fault), 64'h1);
        chk("R8 rd kept", 64'(rd), 64'h100);
        @(negedge clk);
        chk("R8 fault one cycle", 64'(fault), 64'h0);
        wr_csr(32'h8000_0000);
        chk("R8 fault bit31", 64'(fault), 64'h1);
        chk("R8 rd kept 31", 64'(rd), 64'h100);
        wr_csr(32'h142);
        chk("R8 legal no fault", 64'(fault), 64'h0);
        chk("R8 legal value", 64'(rd), 64'h142);

        // R9 unsupported flush
        wr_nd(32'h100);
        chk("R9 zero legal", 64'(nd_fault), 64'h0);
        chk("R9 rd", 64'(nd_rd), 64'h100);
        wr_nd(32'h140);
        chk("R9 set faults", 64'(nd_fault), 64'h1);
        chk("R9 bit6 zero", 64'(nd_rd), 64'h100);
        @(negedge clk); op_valid = 1'b1; op_dp = 1'b1; op_in = 64'h1;
        #1 chk("R9 no flush", nd_out, 64'h1);
        @(negedge clk); op_valid = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule